// File: doc/BRIEF.md
# Reed-Solomon Sector Parity Engine

This block computes and checks the parity of one flash page sector as its bytes stream past, one per clock. Symbols are 10 bits wide, taken from GF(2^10), and the generator polynomial has six consecutive roots. In generate mode the block keeps six parity symbols, updated for every sector byte it accepts. Software then reads those symbols as eight packed bytes and stores them next to the sector.

In check mode the block takes the sector bytes followed by the eight stored parity bytes. It then reports whether the remainder is nonzero. The remainder itself can be read as eight bit-reversed bytes, which an external decoder uses to correct the errors.

Every sector byte is inverted before encoding, and the parity is read out inverted. As a result, an erased sector of all 0xFF bytes has parity bytes that are also all 0xFF. The block finds errors but does not correct them.

Top module: `rsParityEngine`

## Requirements
- R1: A control write with bit 7 set zeroes the six parity symbols, the byte count and the error flag. After the clear, every parity-window byte reads 0xFF, every remainder-window byte reads 0x00 and `chkStatus` reads 0x00.
- R2: A control write with bit 5 set enables the byte feed. A write with bit 5 clear stops it. Bytes presented while the feed is off, or while `inValid` is low, change nothing at any output.
- R3: In generate mode each accepted byte b enters the encoder as the 10-bit symbol {2'b00, ~b}. The polynomial is x^10+x^3+1, and the degree-6 generator has roots alpha^0 to alpha^5. Parity symbol k is the coefficient of x^k in x^6·m(x) mod g(x). A sector of all 0xFF therefore reads back eight bytes of 0xFF.
- R4: The symbols are packed LSB-first into a 64-bit word. Symbol k occupies bits [10·(5−k)+9 : 10·(5−k)], so symbol 5 starts in byte 0 and symbol 0 ends in byte 7. Bits 63:60 are pad. Parity-window byte i (`rdSel`=0, `rdIdx`=i) is the bitwise inverse of word bits [8i+7:8i].
- R5: The upper four bits of parity-window byte 7 always read as ones.
- R6: In generate mode only the first DataBytes accepted bytes are used. Any further bytes before the next clear have no effect.
- R7: In check mode the engine first takes DataBytes sector bytes, then 8 stored parity bytes. Each stored byte is inverted and unpacked with the R4 layout, ignoring the top nibble of byte 7. The symbols are fed in the order 5, 4, 3, 2, 1, 0. In the cycle after the eighth parity byte is accepted, `chkStatus` bit 7 becomes 1 if the remainder is nonzero and 0 if it is zero. The other bits of `chkStatus` are always 0. Bytes after the eighth parity byte are ignored.
- R8: Remainder-window byte i (`rdSel`=1) is the bit-reversal of word bits [8i+7:8i], with the pad bits taken as zero.
- R9: The error flag and both readout windows hold their values across idle cycles and disabled-feed bytes until the next clear.
- R10: The mode bit (bit 6: 1 = generate, 0 = check) is taken from any control write that has bit 5 set. A write with bit 5 clear leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | 8 | Control value: bit 7 clear, bit 6 generate, bit 5 feed enable |
| inValid | input | 1 | Byte strobe for `inByte` |
| inByte | input | 8 | Sector or stored-parity byte |
| rdSel | input | 1 | Readout window: 0 = inverted parity, 1 = bit-reversed remainder |
| rdIdx | input | 3 | Readout byte index |
| rdData | output | 8 | Selected readout byte, combinational from state |
| chkStatus | output | 8 | Check register; bit 7 = error detected |

## Verification
A wrong coefficient, tap or feed order corrupts the parity symbols. Both readout windows then differ from the reference on the very next cycle, and stay wrong for the rest of the sector. A fault in the parity-byte unpacking, or in the check of the top nibble of byte 7, shows only as a wrong `chkStatus` bit 7 in the cycle after the eighth parity byte. A counter that lets extra bytes through shows as drifting readout bytes after the sector boundary.

// File: rtl/rsEnginePkg.sv
package rsEnginePkg;
  localparam int SymW      = 10;
  localparam int ParSyms   = 6;
  localparam int ParBytes  = 8;
  localparam int PackW     = ParBytes * 8;
  localparam int PadW      = PackW - SymW * ParSyms;
  localparam int FirstRoot = 0;
  localparam logic [SymW-1:0] ReduceMask = 10'h009; // x^10 = x^3 + 1
  localparam int ClrBit  = 7;
  localparam int GenBit  = 6;
  localparam int FeedBit = 5;
  localparam int ErrBit  = 7;

  typedef logic [SymW-1:0] symT;
  typedef symT [ParSyms-1:0] parVecT;

  typedef struct packed {
    logic       clear;
    logic       shiftData;
    logic       shiftPar;
    logic [2:0] parIdx;
    logic       lastPar;
  } ctlStrobeT;

  function automatic symT gfMul(symT a, symT b);
    symT acc;
    acc = '0;
    for (int i = SymW - 1; i >= 0; i--) begin
      acc = {acc[SymW-2:0], 1'b0} ^ (acc[SymW-1] ? ReduceMask : '0);
      if (b[i]) acc = acc ^ a;
    end
    return acc;
  endfunction

  function automatic symT gfAlphaPow(int e);
    symT v;
    v = symT'(1);
    for (int i = 0; i < e; i++) v = gfMul(v, symT'(2));
    return v;
  endfunction

  // Low six coefficients of the monic degree-6 generator
  function automatic parVecT genPoly();
    symT c [0:ParSyms];
    symT root;
    parVecT res;
    for (int j = 0; j <= ParSyms; j++) c[j] = '0;
    c[0] = symT'(1);
    for (int r = 0; r < ParSyms; r++) begin
      root = gfAlphaPow(FirstRoot + r);
      for (int j = ParSyms; j >= 1; j--) c[j] = c[j-1] ^ gfMul(c[j], root);
      c[0] = gfMul(c[0], root);
    end
    for (int j = 0; j < ParSyms; j++) res[j] = c[j];
    return res;
  endfunction

  function automatic logic [7:0] rev8(logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction
endpackage

// File: rtl/rsCtrl.sv
module rsCtrl
  import rsEnginePkg::*;
#(
  parameter int DataBytes = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWrEn,
  input  logic [7:0] ctlWrData,
  input  logic       inValid,
  output ctlStrobeT  strobe
);
  localparam int TotalBytes = DataBytes + ParBytes;
  localparam int CntW = $clog2(TotalBytes + 1);

  logic feedEn;
  logic genMode;
  logic [CntW-1:0] byteCnt;
  logic clearReq;
  logic accept;
  logic inDataPhase;
  logic inParPhase;
  logic unusedCtlBits;

  assign unusedCtlBits = ^ctlWrData[4:0];
  assign clearReq    = ctlWrEn & ctlWrData[ClrBit];
  assign accept      = inValid & feedEn & ~clearReq;
  assign inDataPhase = byteCnt < CntW'(DataBytes);
  assign inParPhase  = ~genMode & ~inDataPhase & (byteCnt < CntW'(TotalBytes));

  always_comb begin
    strobe.clear     = clearReq;
    strobe.shiftData = accept & inDataPhase;
    strobe.shiftPar  = accept & inParPhase;
    strobe.parIdx    = 3'(byteCnt - CntW'(DataBytes));
    strobe.lastPar   = (3'(byteCnt - CntW'(DataBytes)) == 3'd7);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      feedEn  <= 1'b0;
      genMode <= 1'b0;
    end else if (ctlWrEn) begin
      feedEn <= ctlWrData[FeedBit];
      if (ctlWrData[FeedBit]) genMode <= ctlWrData[GenBit];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) byteCnt <= '0;
    else if (clearReq) byteCnt <= '0;
    else if (strobe.shiftData | strobe.shiftPar) byteCnt <= byteCnt + 1'b1;
  end

  // R7
  parity_only_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftPar |-> !genMode);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= CntW'(TotalBytes));

  // R2
  feed_off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!feedEn && !clearReq) |=> $stable(byteCnt));
endmodule

// File: rtl/rsDatapath.sv
module rsDatapath
  import rsEnginePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobeT  strobe,
  input  logic [7:0] inByte,
  input  logic       rdSel,
  input  logic [2:0] rdIdx,
  output logic [7:0] rdData,
  output logic       errFlag
);
  localparam parVecT GenCoef = genPoly();

  parVecT parState;
  parVecT nextState;
  parVecT tapProd;
  logic [7:0] prevPar;
  logic [7:0] parByte;
  symT dataSym;
  symT parSym;
  symT feedSym;
  symT feedBack;
  logic symReady;
  logic doStep;
  logic [PackW-1:0] packedBits;
  logic [7:0] selByte;

  assign parByte = ~inByte;
  assign dataSym = {{(SymW-8){1'b0}}, ~inByte};

  // Stored parity unpacking: each byte completes at most one symbol
  always_comb begin
    symReady = 1'b1;
    parSym   = '0;
    unique case (strobe.parIdx)
      3'd1: parSym = {parByte[1:0], prevPar};
      3'd2: parSym = {parByte[3:0], prevPar[7:2]};
      3'd3: parSym = {parByte[5:0], prevPar[7:4]};
      3'd4: parSym = {parByte, prevPar[7:6]};
      3'd6: parSym = {parByte[1:0], prevPar};
      3'd7: parSym = {parByte[3:0], prevPar[7:2]};
      default: symReady = 1'b0;
    endcase
  end

  assign feedSym  = strobe.shiftData ? dataSym : parSym;
  assign doStep   = strobe.shiftData | (strobe.shiftPar & symReady);
  assign feedBack = feedSym ^ parState[ParSyms-1];

  for (genvar j = 0; j < ParSyms; j++) begin : tapGen
    assign tapProd[j] = gfMul(feedBack, GenCoef[j]);
    if (j == 0) begin : lowTap
      assign nextState[j] = tapProd[j];
    end else begin : midTap
      assign nextState[j] = parState[j-1] ^ tapProd[j];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parState <= '0;
      prevPar  <= '0;
      errFlag  <= 1'b0;
    end else if (strobe.clear) begin
      parState <= '0;
      prevPar  <= '0;
      errFlag  <= 1'b0;
    end else begin
      if (doStep) parState <= nextState;
      if (strobe.shiftPar) prevPar <= parByte;
      if (strobe.shiftPar && strobe.lastPar) errFlag <= |nextState;
    end
  end

  for (genvar k = 0; k < ParSyms; k++) begin : packGen
    assign packedBits[SymW*(ParSyms-1-k) +: SymW] = parState[k];
  end
  assign packedBits[PackW-1 -: PadW] = '0;

  assign selByte = packedBits[{rdIdx, 3'b000} +: 8];
  assign rdData  = rdSel ? rev8(selByte) : ~selByte;

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (parState == '0) && !errFlag);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.clear || strobe.shiftData || strobe.shiftPar)
      |=> $stable(parState) && $stable(errFlag));

  // R7
  flag_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(strobe.shiftPar && strobe.lastPar));
endmodule

// File: rtl/rsParityEngine.sv
module rsParityEngine
  import rsEnginePkg::*;
#(
  parameter int DataBytes = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWrEn,
  input  logic [7:0] ctlWrData,
  input  logic       inValid,
  input  logic [7:0] inByte,
  input  logic       rdSel,
  input  logic [2:0] rdIdx,
  output logic [7:0] rdData,
  output logic [7:0] chkStatus
);
  ctlStrobeT strobe;
  logic errFlag;

  rsCtrl #(.DataBytes(DataBytes)) uCtrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .inValid(inValid), .strobe(strobe)
  );

  rsDatapath uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inByte(inByte),
    .rdSel(rdSel), .rdIdx(rdIdx), .rdData(rdData), .errFlag(errFlag)
  );

  always_comb begin
    chkStatus = '0;
    chkStatus[ErrBit] = errFlag;
  end
endmodule

// File: tb/tb_rsParityEngine.sv
module tb_rsParityEngine;
  localparam int DB = 512;

  logic clk = 0;
  logic rstN = 0;
  logic ctlWrEn = 0;
  logic [7:0] ctlWrData = 0;
  logic inValid = 0;
  logic [7:0] inByte = 0;
  logic rdSel = 0;
  logic [2:0] rdIdx = 0;
  logic [7:0] rdData;
  logic [7:0] chkStatus;

  rsParityEngine #(.DataBytes(DB)) dut (.*);

  always #10 clk = ~clk; // 50 MHz

  int compared = 0, mismatched = 0, cycles = 0;
  string curReq = "R1";

  // GF(2^10) by log tables
  int expT [0:1023];
  int logT [0:1023];
  int gB [0:6];

  function automatic int mulB(int a, int b);
    if (a == 0 || b == 0) return 0;
    return expT[(logT[a] + logT[b]) % 1023];
  endfunction

  task automatic buildField();
    int v;
    v = 1;
    for (int i = 0; i < 1023; i++) begin
      expT[i] = v; logT[v] = i;
      v = v << 1;
      if (v & 1024) v = v ^ 'h409;
    end
    for (int j = 0; j <= 6; j++) gB[j] = 0;
    gB[0] = 1;
    for (int r = 0; r < 6; r++) begin
      for (int j = 6; j >= 1; j--) gB[j] = gB[j-1] ^ mulB(gB[j], expT[r]);
      gB[0] = mulB(gB[0], expT[r]);
    end
  endtask

  // Reference model state
  int sym [$];
  int pb [0:7];
  int cnt = 0;
  bit feedM = 0, genM = 0, flagM = 0, dirty = 1, clrNow;
  int remC [0:5];
  bit [63:0] expPacked;

  task automatic remCalc();
    int n, c;
    int P [];
    n = sym.size();
    P = new[n + 6];
    for (int i = 0; i < n + 6; i++) P[i] = (i < n) ? sym[i] : 0;
    for (int i = 0; i < n; i++) begin
      c = P[i];
      if (c != 0) for (int j = 0; j <= 6; j++) P[i+j] = P[i+j] ^ mulB(c, gB[6-j]);
    end
    for (int k = 0; k < 6; k++) remC[k] = P[n + 5 - k];
    expPacked = '0;
    for (int k = 0; k < 6; k++) expPacked[10*(5-k) +: 10] = remC[k][9:0];
  endtask

  task automatic acceptByte(input logic [7:0] b);
    int k, v;
    v = int'(~b) & 255;
    if (cnt < DB) begin
      sym.push_back(v); cnt++; dirty = 1;
    end else if (!genM && cnt < DB + 8) begin
      k = cnt - DB; pb[k] = v; cnt++;
      case (k)
        1: sym.push_back(((pb[1] & 3) << 8) | pb[0]);
        2: sym.push_back(((pb[2] & 15) << 6) | (pb[1] >> 2));
        3: sym.push_back(((pb[3] & 63) << 4) | (pb[2] >> 4));
        4: sym.push_back((pb[4] << 2) | (pb[3] >> 6));
        6: sym.push_back(((pb[6] & 3) << 8) | pb[5]);
        7: sym.push_back(((pb[7] & 15) << 6) | (pb[6] >> 2));
        default: ;
      endcase
      dirty = 1;
      if (k == 7) begin
        remCalc(); dirty = 0;
        flagM = (expPacked != 0);
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      sym.delete(); cnt = 0; feedM = 0; genM = 0; flagM = 0; dirty = 1;
    end else begin
      clrNow = ctlWrEn && ctlWrData[7];
      if (!clrNow && inValid && feedM) acceptByte(inByte);
      if (ctlWrEn) begin
        if (ctlWrData[7]) begin sym.delete(); cnt = 0; flagM = 0; dirty = 1; end
        feedM = ctlWrData[5];
        if (ctlWrData[5]) genM = ctlWrData[6];
      end
    end
  end

  function automatic logic [7:0] revB(logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  // Comparison on every clock, mid-cycle
  always @(posedge clk) begin
    logic [7:0] raw, expB;
    #5;
    cycles++;
    if (dirty) begin remCalc(); dirty = 0; end
    raw = expPacked[{rdIdx, 3'b000} +: 8];
    expB = rdSel ? revB(raw) : ~raw;
    compared++;
    if (rdData !== expB) begin
      mismatched++;
      $display("FAIL %s rdData sel=%0d idx=%0d got %02h exp %02h", curReq, rdSel, rdIdx, rdData, expB);
    end
    compared++;
    if (chkStatus !== {flagM, 7'b0}) begin
      mismatched++;
      $display("FAIL %s chkStatus got %02h exp %02h", curReq, chkStatus, {flagM, 7'b0});
    end
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog got %0d cycles exp finish", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // Rotate through both windows
  logic [3:0] rot = 0;
  always @(negedge clk) begin
    rot <= rot + 1;
    {rdSel, rdIdx} <= rot + 1;
  end

  task automatic drive(input logic we, input logic [7:0] wd, input logic v, input logic [7:0] b);
    @(negedge clk);
    ctlWrEn = we; ctlWrData = wd; inValid = v; inByte = b;
  endtask
  task automatic ctl(input logic [7:0] wd); drive(1, wd, 0, 0); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) drive(0, 0, 0, 0); endtask
  task automatic put(input logic [7:0] b); drive(0, 0, 1, b); endtask

  logic [7:0] dataA [0:DB-1];
  logic [7:0] stored [0:7];

  task automatic sendSector(input int flipAt, input logic [7:0] flipMask, input bit gaps);
    for (int i = 0; i < DB; i++) begin
      put((i == flipAt) ? (dataA[i] ^ flipMask) : dataA[i]);
      if (gaps && (i % 5 == 0)) idle(1);
    end
  endtask

  task automatic sendStored(input int flipIdx, input logic [7:0] flipMask);
    for (int i = 0; i < 8; i++) put((i == flipIdx) ? (stored[i] ^ flipMask) : stored[i]);
  endtask

  initial begin
    buildField();
    for (int i = 0; i < DB; i++) dataA[i] = 8'((i * 37 + 11) ^ (i >> 3));
    idle(3);
    rstN = 1;
    curReq = "R1"; idle(18);

    curReq = "R5"; ctl(8'hE0);
    for (int i = 0; i < DB; i++) put(8'hFF);
    ctl(8'h00); idle(20);

    curReq = "R3"; ctl(8'hE0); sendSector(-1, 0, 1); ctl(8'h00); idle(20);
    for (int i = 0; i < 8; i++) stored[i] = ~expPacked[8*i +: 8];

    curReq = "R6"; ctl(8'hE0); sendSector(-1, 0, 0);
    for (int i = 0; i < 6; i++) put(8'h5A);
    curReq = "R4"; ctl(8'h00); idle(20);

    curReq = "R2"; for (int i = 0; i < 10; i++) put(8'(i * 3)); idle(20);

    curReq = "R7"; ctl(8'hA0); sendSector(-1, 0, 1); sendStored(-1, 0);
    for (int i = 0; i < 4; i++) put(8'hC3);
    idle(20); ctl(8'h00);

    curReq = "R8"; ctl(8'hA0); sendSector(100, 8'h10, 0); sendStored(-1, 0); idle(20);
    curReq = "R9"; ctl(8'h00); idle(10);
    for (int i = 0; i < 5; i++) put(8'h77); idle(20);

    curReq = "R10"; ctl(8'h80); idle(18); ctl(8'h20);
    sendSector(-1, 0, 0); sendStored(7, 8'hF0); idle(20);
    curReq = "R7"; ctl(8'hA0); sendSector(-1, 0, 0); sendStored(3, 8'h01); idle(20);

    curReq = "R1"; ctl(8'h80); idle(20);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule